// File: doc/BRIEF.md
# Daisy-Chain DAC Update Controller

This block is a host-side serial master that refreshes a chain of cascaded 12-bit DACs. All devices share one serial clock and one active-low frame line. The serial data output of each device feeds the data input of the next. The host places one 12-bit code and one 2-bit power-down select per device on a parallel bus and pulses `start`. The controller then builds a 16-bit word for every device and concatenates the words into a single stream of 16×N bits.

The controller pulls the frame line low and shifts the whole stream with the data changing only while the serial clock is high. It then releases the frame line, so every device in the chain takes its new word at the same instant. Between frames it keeps the frame line high for a programmable number of cycles. The serial clock divider is picked from the chain length, because a chained bus must run slower than a single device. The setup delay before the first clock edge and the minimum frame-high time are parameters counted in system clock cycles.

Top module: `dac_chain_master`

## Requirements
- R1: While `rst` is high, and after its release, `frame_n` and `ser_clk` are 1 and `busy` and `done` are 0. `ser_clk` is 1 whenever `frame_n` is 1.
- R2: Each accepted request produces exactly 16×N_DEV falling edges of `ser_clk`, all while `frame_n` is 0.
- R3: The 16-bit word for a device is sent MSB first and laid out as follows: bits 15:14 are 0 (padding), bits 13:12 are that device's power-down select, and bits 11:0 are its code.
- R4: Device k's code is `dac_codes[12k+11:12k]` and its select is `pd_modes[2k+1:2k]`, where device 0 sits next to the host. The word of device N_DEV-1 is sent first and the word of device 0 is sent last, so after the frame every device holds its own word.
- R5: `ser_data` changes only on a rising edge of `ser_clk` or while `ser_clk` is high. It never changes while `ser_clk` stays low.
- R6: Each half period of `ser_clk` lasts HALF_CHAIN system cycles when N_DEV > 1 and HALF_SOLO cycles when N_DEV = 1.
- R7: The first falling edge of `ser_clk` comes exactly SETUP_CYC + half-period cycles after `frame_n` falls.
- R8: `frame_n` rises together with `ser_clk`, exactly one half period after the last falling edge.
- R9: `busy` is 1 from the cycle in which `frame_n` falls until `frame_n` has been high for GAP_CYC cycles. At that point `done` is 1 for exactly one cycle and `busy` drops in the same cycle. `frame_n` stays high at least GAP_CYC cycles between frames.
- R10: A `start` pulse while `busy` is 1 is ignored. Changes on `dac_codes` or `pd_modes` after acceptance do not affect the frame in progress.
- R11: No device's latched word changes during the frame. Every device's word changes only on the rise of `frame_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a chain update; accepted when `busy` is 0 |
| dac_codes | input | 12×N_DEV | Per-device 12-bit codes, device 0 in the low bits |
| pd_modes | input | 2×N_DEV | Per-device power-down selects, device 0 in the low bits |
| busy | output | 1 | Frame or inter-frame gap in progress |
| done | output | 1 | One-cycle pulse when the gap ends |
| ser_clk | output | 1 | Serial clock to the chain, idles high |
| frame_n | output | 1 | Active-low frame line shared by the chain |
| ser_data | output | 1 | Serial data to the first device |

## Verification
The hardest case to reach from the ports is proving that no device updates early. Data passes through every device's shift register on its way down the chain, so a stray mid-frame latch would look like a correct but shifted word. The bench connects a chain of behavioural slave models and samples each slave's latched word halfway through a frame, when the data of the current frame is already moving through the chain. It also injects a second start pulse and changes the parallel inputs at that moment, then checks after completion that exactly one frame ran and that every slave holds the originally requested word.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 12;
  localparam int PD_W   = 2;
  localparam int PAD_W  = WORD_W - PD_W - CODE_W;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_SHIFT = 2'd2,
    SEQ_GAP   = 2'd3
  } seq_state_t;

  function automatic logic [WORD_W-1:0] pack_word(input logic [PD_W-1:0] pd,
                                                  input logic [CODE_W-1:0] code);
    return {{PAD_W{1'b0}}, pd, code};
  endfunction
endpackage

// File: rtl/dcm_frame_pack.sv
module dcm_frame_pack
  import dcm_pkg::*;
#(
  parameter int N_DEV = 4
) (
  input  logic [N_DEV*CODE_W-1:0] codes,
  input  logic [N_DEV*PD_W-1:0]   pds,
  output logic [N_DEV*WORD_W-1:0] frame
);
  // Device k occupies slot k; the top slot (farthest device) leaves first.
  for (genvar k = 0; k < N_DEV; k++) begin : g_slot
    assign frame[k*WORD_W +: WORD_W] = pack_word(pds[k*PD_W +: PD_W],
                                                 codes[k*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/dcm_half_div.sv
module dcm_half_div #(
  parameter int HALF = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // Two ticks back to back would give a zero-length half period.
  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dcm_edge_count.sv
module dcm_edge_count #(
  parameter int TOTAL = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(TOTAL + 1);
  logic [CW-1:0] count;

  assign last = (count == CW'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(TOTAL));
  assert_no_extra_fall_R2: assert property (@(posedge clk) disable iff (rst)
    inc |-> !last);
endmodule

// File: rtl/dac_chain_master.sv
module dac_chain_master
  import dcm_pkg::*;
#(
  parameter int N_DEV      = 4,
  parameter int HALF_CHAIN = 10,
  parameter int HALF_SOLO  = 2,
  parameter int SETUP_CYC  = 3,
  parameter int GAP_CYC    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [N_DEV*CODE_W-1:0]  dac_codes,
  input  logic [N_DEV*PD_W-1:0]    pd_modes,
  output logic                     busy,
  output logic                     done,
  output logic                     ser_clk,
  output logic                     frame_n,
  output logic                     ser_data
);
  localparam int TOTAL    = N_DEV * WORD_W;
  localparam int HALF     = (N_DEV > 1) ? HALF_CHAIN : HALF_SOLO;
  localparam int WAIT_MAX = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int WW       = $clog2(WAIT_MAX + 1);

  seq_state_t        state;
  logic [TOTAL-1:0]  frame_word;
  logic [TOTAL-1:0]  shreg;
  logic [WW-1:0]     wcnt;
  logic              sclk_q, frame_q, busy_q, done_q;
  logic              tick, bits_last, accept, fall_now;

  assign accept   = (state == SEQ_IDLE) && start;
  assign fall_now = (state == SEQ_SHIFT) && tick && sclk_q;

  dcm_frame_pack #(.N_DEV(N_DEV)) u_pack (
    .codes (dac_codes),
    .pds   (pd_modes),
    .frame (frame_word)
  );

  dcm_half_div #(.HALF(HALF)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (state == SEQ_SHIFT),
    .tick (tick)
  );

  dcm_edge_count #(.TOTAL(TOTAL)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .inc  (fall_now),
    .last (bits_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      shreg   <= '0;
      wcnt    <= '0;
      sclk_q  <= 1'b1;
      frame_q <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            shreg   <= frame_word;
            frame_q <= 1'b0;
            busy_q  <= 1'b1;
            wcnt    <= '0;
            state   <= SEQ_SETUP;
          end
        end
        SEQ_SETUP: begin
          if (wcnt == WW'(SETUP_CYC - 1)) begin
            wcnt  <= '0;
            state <= SEQ_SHIFT;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        SEQ_SHIFT: begin
          if (tick) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else if (bits_last) begin
              sclk_q  <= 1'b1;
              frame_q <= 1'b1;
              shreg   <= '0;
              wcnt    <= '0;
              state   <= SEQ_GAP;
            end else begin
              sclk_q <= 1'b1;
              shreg  <= {shreg[TOTAL-2:0], 1'b0};
            end
          end
        end
        default: begin
          if (wcnt == WW'(GAP_CYC - 1)) begin
            wcnt   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            state  <= SEQ_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign ser_clk  = sclk_q;
  assign frame_n  = frame_q;
  assign ser_data = shreg[TOTAL-1];

  assert_clk_idle_R1: assert property (@(posedge clk) disable iff (rst)
    frame_q |-> sclk_q);
  assert_busy_cover_R9: assert property (@(posedge clk) disable iff (rst)
    !frame_q |-> busy_q);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_release_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && frame_q));
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !sclk_q |=> (sclk_q || $stable(ser_data)));
  assert_rise_after_all_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_q) |-> bits_last);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_q && start && state != SEQ_GAP) |=> busy_q);
endmodule

// File: tb/dac_chain_master_test.sv
module dac_slave_model (
  input  logic        rst,
  input  logic        sclk,
  input  logic        frame_n,
  input  logic        din,
  output logic        dout,
  output logic [15:0] word
);
  logic [15:0] sh = '0;
  initial word = '0;
  assign dout = sh[15];
  always @(negedge sclk) if (!frame_n) sh <= {sh[14:0], din};
  always @(posedge frame_n or posedge rst)
    if (rst) word <= '0; else word <= sh;
endmodule

module dcm_bus_monitor (
  input  logic clk, sclk, frame_n, sdata,
  output int   falls, first_dly, last_gap, half_min, half_max, high_min, sdo_bad, frames
);
  int cyc = 0, t_fall = 0, t_edge = 0, t_rise = 0;
  logic p_sclk = 1'b1, p_fn = 1'b1, p_sd = 1'b0;
  bit seen_rise = 0;
  initial begin
    falls = 0; first_dly = 0; last_gap = 0; half_min = 1000000; half_max = 0;
    high_min = 1000000; sdo_bad = 0; frames = 0;
  end
  always @(negedge clk) begin
    cyc++;
    if (p_fn && !frame_n) begin
      frames++; falls = 0; half_min = 1000000; half_max = 0; t_fall = cyc;
      if (seen_rise && (cyc - t_rise) < high_min) high_min = cyc - t_rise;
    end
    if (!p_fn && frame_n) begin
      last_gap = cyc - t_edge; t_rise = cyc; seen_rise = 1;
    end
    if (!frame_n && sclk != p_sclk) begin
      if (!sclk && falls == 0) first_dly = cyc - t_fall;
      else begin
        if (cyc - t_edge < half_min) half_min = cyc - t_edge;
        if (cyc - t_edge > half_max) half_max = cyc - t_edge;
      end
      if (!sclk) falls++;
      t_edge = cyc;
    end
    if (!sclk && !p_sclk && sdata != p_sd) sdo_bad++;
    p_sclk = sclk; p_fn = frame_n; p_sd = sdata;
  end
endmodule

module dac_chain_master_test;
  localparam int NC = 4;
  localparam int HC = 10;
  localparam int HS = 2;
  localparam int SU = 3;
  localparam int GP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst;
  int checks = 0, errors = 0;

  logic              c_start, c_busy, c_done, c_sclk, c_fn, c_sd;
  logic [NC*12-1:0]  c_codes;
  logic [NC*2-1:0]   c_pds;
  logic              s_start, s_busy, s_done, s_sclk, s_fn, s_sd;
  logic [11:0]       s_codes;
  logic [1:0]        s_pds;

  dac_chain_master #(.N_DEV(NC), .HALF_CHAIN(HC), .HALF_SOLO(HS), .SETUP_CYC(SU), .GAP_CYC(GP)) uut (
    .clk(clk), .rst(rst), .start(c_start), .dac_codes(c_codes), .pd_modes(c_pds),
    .busy(c_busy), .done(c_done), .ser_clk(c_sclk), .frame_n(c_fn), .ser_data(c_sd));

  dac_chain_master #(.N_DEV(1), .HALF_CHAIN(HC), .HALF_SOLO(HS), .SETUP_CYC(SU), .GAP_CYC(GP)) uut_solo (
    .clk(clk), .rst(rst), .start(s_start), .dac_codes(s_codes), .pd_modes(s_pds),
    .busy(s_busy), .done(s_done), .ser_clk(s_sclk), .frame_n(s_fn), .ser_data(s_sd));

  wire        c_link [0:NC];
  wire [15:0] c_word [NC];
  wire        s_out;
  wire [15:0] s_word;
  assign c_link[0] = c_sd;
  for (genvar k = 0; k < NC; k++) begin : g_sl
    dac_slave_model sl (.rst(rst), .sclk(c_sclk), .frame_n(c_fn), .din(c_link[k]),
                        .dout(c_link[k+1]), .word(c_word[k]));
  end
  dac_slave_model sl_solo (.rst(rst), .sclk(s_sclk), .frame_n(s_fn), .din(s_sd),
                           .dout(s_out), .word(s_word));

  int mc_falls, mc_first, mc_last, mc_hmin, mc_hmax, mc_high, mc_bad, mc_frames;
  int ms_falls, ms_first, ms_last, ms_hmin, ms_hmax, ms_high, ms_bad, ms_frames;
  dcm_bus_monitor mon_c (.clk(clk), .sclk(c_sclk), .frame_n(c_fn), .sdata(c_sd),
    .falls(mc_falls), .first_dly(mc_first), .last_gap(mc_last), .half_min(mc_hmin),
    .half_max(mc_hmax), .high_min(mc_high), .sdo_bad(mc_bad), .frames(mc_frames));
  dcm_bus_monitor mon_s (.clk(clk), .sclk(s_sclk), .frame_n(s_fn), .sdata(s_sd),
    .falls(ms_falls), .first_dly(ms_first), .last_gap(ms_last), .half_min(ms_hmin),
    .half_max(ms_hmax), .high_min(ms_high), .sdo_bad(ms_bad), .frames(ms_frames));

  logic [15:0] prev_c [NC];
  logic [15:0] prev_s;

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_ge(input string what, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s: got %0d expected at least %0d", what, act, lim);
    end
  endtask

  function automatic logic [11:0] code_of(input int f, input int k);
    if (f == 0) return 12'h000;
    if (f == 1) return 12'hFFF;
    return 12'((f * 667 + k * 1235 + 17 * f * k) & 4095);
  endfunction

  function automatic logic [1:0] pd_of(input int f, input int k);
    if (f == 0) return 2'd0;
    if (f == 1) return 2'd3;
    return 2'((f + k) & 3);
  endfunction

  task automatic run_chain(input int f);
    int fr0;
    fr0 = mc_frames;
    @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      c_codes[k*12 +: 12] = code_of(f, k);
      c_pds[k*2 +: 2]     = pd_of(f, k);
    end
    c_start = 1'b1;
    @(negedge clk);
    c_start = 1'b0;
    c_codes = ~c_codes;
    c_pds   = ~c_pds;
    chk("R9 chain busy after accept", int'(c_busy), 1);
    repeat (500) @(negedge clk);
    for (int k = 0; k < NC; k++)
      chk($sformatf("R11 chain dev%0d word held mid-frame", k), int'(c_word[k]), int'(prev_c[k]));
    c_start = 1'b1;
    c_codes = '1;
    @(negedge clk);
    c_start = 1'b0;
    while (!c_done) @(negedge clk);
    chk("R9 busy low with done", int'(c_busy), 0);
    chk("R10 single frame per request", mc_frames, fr0 + 1);
    chk("R2 chain falling edges", mc_falls, NC * 16);
    chk("R7 chain setup delay", mc_first, SU + HC);
    chk("R6 chain half period min", mc_hmin, HC);
    chk("R6 chain half period max", mc_hmax, HC);
    chk("R8 chain last fall to rise", mc_last, HC);
    chk("R5 chain data changes while clock low", mc_bad, 0);
    if (f > 0) chk_ge("R9 chain frame high time", mc_high, GP);
    for (int k = 0; k < NC; k++) begin
      logic [15:0] w;
      w = c_word[k];
      chk($sformatf("R3 chain dev%0d pad bits", k), int'(w[15:14]), 0);
      chk($sformatf("R4 chain dev%0d code", k), int'(w[11:0]), int'(code_of(f, k)));
      chk($sformatf("R4 chain dev%0d pd select", k), int'(w[13:12]), int'(pd_of(f, k)));
      prev_c[k] = w;
    end
    @(negedge clk);
    chk("R9 chain done one cycle", int'(c_done), 0);
  endtask

  task automatic run_solo(input int f);
    int fr0;
    fr0 = ms_frames;
    @(negedge clk);
    s_codes = code_of(f, 5);
    s_pds   = pd_of(f, 5);
    s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    s_codes = ~s_codes;
    s_pds   = ~s_pds;
    repeat (30) @(negedge clk);
    chk("R11 solo word held mid-frame", int'(s_word), int'(prev_s));
    s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    while (!s_done) @(negedge clk);
    chk("R10 solo single frame", ms_frames, fr0 + 1);
    chk("R2 solo falling edges", ms_falls, 16);
    chk("R7 solo setup delay", ms_first, SU + HS);
    chk("R6 solo half period min", ms_hmin, HS);
    chk("R6 solo half period max", ms_hmax, HS);
    chk("R8 solo last fall to rise", ms_last, HS);
    chk("R5 solo data changes while clock low", ms_bad, 0);
    if (f > 0) chk_ge("R9 solo frame high time", ms_high, GP);
    chk("R3 solo pad bits", int'(s_word[15:14]), 0);
    chk("R4 solo code", int'(s_word[11:0]), int'(code_of(f, 5)));
    chk("R4 solo pd select", int'(s_word[13:12]), int'(pd_of(f, 5)));
    prev_s = s_word;
    @(negedge clk);
    chk("R9 solo done one cycle", int'(s_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    c_start = 1'b0; c_codes = '0; c_pds = '0;
    s_start = 1'b0; s_codes = '0; s_pds = '0;
    for (int k = 0; k < NC; k++) prev_c[k] = '0;
    prev_s = '0;
    repeat (5) @(negedge clk);
    chk("R1 reset frame_n", int'(c_fn), 1);
    chk("R1 reset ser_clk", int'(c_sclk), 1);
    chk("R1 reset busy", int'(c_busy), 0);
    chk("R1 reset done", int'(c_done), 0);
    chk("R1 solo reset frame_n", int'(s_fn), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle ser_clk high", int'(c_sclk), 1);
    for (int f = 0; f < 8; f++) run_chain(f);
    for (int f = 0; f < 6; f++) run_solo(f);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule